// File: doc/BRIEF.md
# Chassis Intrusion Latch with Wake and Interrupt Events

This block records the opening of a chassis cover. The cover switch drives an active-low, glitch-free input. A falling edge on that input sets a sticky intrusion flag. The flag survives the loss of main and standby power because it is modelled as living in an always-on battery domain. An intrusion that happens while only the battery is present is also remembered as a pending event. That pending event is replayed into the event status bits when standby power comes back.

Two event paths report an intrusion to the rest of the system: a power-management wake request and a system-management interrupt. Each path has a status bit and an enable bit, both reachable through a simple register port with a single-cycle write strobe and a combinational read mux. Each event output is a registered copy of status AND enable AND the power-good signal that the path needs. The wake path needs standby power and the interrupt path needs main power. Setting an enable bit while its status bit is already pending therefore raises the output at once.

Three power-domain controls are separate synchronous inputs: a battery power-on reset, a standby power-on reset, and the standby and main power-good levels.

Top module: `chassis_tamper_latch`

## Requirements
- R1: A falling edge on `tamper_n_i` (high in one cycle, low in the next) sets the intrusion flag at the next clock edge. The flag then stays set until software clears it.
- R2: The flag and a pending marker capture an intrusion while `stby_pg` is 0. During that time register writes are ignored and the event status bits do not change.
- R3: `rst_bat_por` sets the flag to 1 and sets the pending marker.
- R4: `rst_stby_por` clears both enable bits and both event outputs. It loads each event status bit with the pending marker (or with 1 if `rst_bat_por` is high in the same cycle). It forces the flag to 1 if the marker was set and otherwise leaves the flag unchanged. It then clears the marker.
- R5: A write with bit 0 equal to 0 to the intrusion register (address 0x5E) clears the flag only while `tamper_n_i` is low. A write with bit 0 equal to 1 leaves the flag unchanged. Reading the intrusion register returns the flag in bit 0, the current pin level in bit 1, and 0 in all other bits.
- R6: While `stby_pg` is 1, a falling edge sets both event status bits. A write with bit 0 equal to 1 to a status address clears that bit, and a falling edge in the same cycle takes priority over the clear.
- R7: `wake_o` equals the wake status AND the wake enable AND `stby_pg`, as they were one cycle earlier.
- R8: `smi_o` equals the interrupt status AND the interrupt enable AND `main_pg` AND `stby_pg`, as they were one cycle earlier.
- R9: Writing 1 to an enable bit while its status bit is set asserts the matching output one cycle after the enable bit is set.
- R10: The register map is wake status 0x40, wake enable 0x41, interrupt status 0x42, interrupt enable 0x43 and intrusion 0x5E. Each event bit sits in bit 0. An enable write loads bit 0 of the write data. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bat_por | input | 1 | Battery-domain power-on reset, synchronous, active high |
| rst_stby_por | input | 1 | Standby-domain power-on reset, synchronous, active high |
| stby_pg | input | 1 | Standby power present |
| main_pg | input | 1 | Main power present |
| tamper_n_i | input | 1 | Cover switch input, low when the cover is open |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| wake_o | output | 1 | Wake event request, registered level |
| smi_o | output | 1 | System-management interrupt, registered level |

## Verification
A wrong flag or status bit shows up in `reg_rdata` in the same cycle it is read, because the read path is combinational. It also shows up on `wake_o` or `smi_o` one clock later whenever the matching enable is set. A lost pending marker stays hidden until the next standby power-on reset, when the status bits come up clear instead of set. For that reason the bench drives battery-only intrusions followed by standby resets and compares each read and each output cycle by cycle against a reference model.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int EV_WAKE = 0;
  localparam int EV_SMI  = 1;
  localparam int NUM_EV  = 2;
endpackage

// File: rtl/tamper_bat_core.sv
// Always-on part: pin edge detect, sticky flag and battery-only pending marker.
module tamper_bat_core (
  input  logic clk,
  input  logic rst_bat_por,
  input  logic rst_stby_por,
  input  logic stby_pg,
  input  logic tamper_n_i,
  input  logic clr_req,
  output logic flag_o,
  output logic pend_o,
  output logic fall_o
);
  logic pin_q, flag_q, pend_q;

  assign fall_o = pin_q & ~tamper_n_i & ~rst_bat_por;
  assign flag_o = flag_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst_bat_por) begin
      pin_q  <= 1'b1;
      flag_q <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      pin_q <= tamper_n_i;
      if (fall_o || (rst_stby_por && pend_q))
        flag_q <= 1'b1;
      else if (clr_req)
        flag_q <= 1'b0;
      if (fall_o && !stby_pg)
        pend_q <= 1'b1;
      else if (rst_stby_por)
        pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tamper_evt_path.sv
// One event path (status, enable, gated registered output) in the standby domain.
module tamper_evt_path #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = '0,
  parameter logic [ADDR_W-1:0] EN_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_stby_por,
  input  logic              pend_in,
  input  logic              stby_pg,
  input  logic              out_pg,
  input  logic              fall,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  output logic              sts_o,
  output logic              en_o,
  output logic              evt_o,
  output logic              rd_hit,
  output logic              rd_bit
);
  logic sts_q, en_q, evt_q;
  logic hit_sts, hit_en;

  assign hit_sts = (addr == STS_ADDR);
  assign hit_en  = (addr == EN_ADDR);

  always_ff @(posedge clk) begin
    if (rst_stby_por) begin
      sts_q <= pend_in;
      en_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= sts_q & en_q & out_pg;
      if (stby_pg) begin
        if (fall)
          sts_q <= 1'b1;
        else if (wr_ok && hit_sts && wbit)
          sts_q <= 1'b0;
        if (wr_ok && hit_en)
          en_q <= wbit;
      end
    end
  end

  assign sts_o  = sts_q;
  assign en_o   = en_q;
  assign evt_o  = evt_q;
  assign rd_hit = hit_sts | hit_en;
  assign rd_bit = hit_sts ? sts_q : en_q;
endmodule

// File: rtl/chassis_tamper_latch.sv
module chassis_tamper_latch
  import tamper_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] TAMPER_ADDR   = 'h5E,
  parameter logic [ADDR_W-1:0] WAKE_STS_ADDR = 'h40,
  parameter logic [ADDR_W-1:0] WAKE_EN_ADDR  = 'h41,
  parameter logic [ADDR_W-1:0] SMI_STS_ADDR  = 'h42,
  parameter logic [ADDR_W-1:0] SMI_EN_ADDR   = 'h43
) (
  input  logic              clk,
  input  logic              rst_bat_por,
  input  logic              rst_stby_por,
  input  logic              stby_pg,
  input  logic              main_pg,
  input  logic              tamper_n_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wake_o,
  output logic              smi_o
);
  logic flag_q, pend_q, fall;
  logic wr_ok, clr_req, pend_in;
  logic [NUM_EV-1:0] ev_sts, ev_en, ev_out, ev_pg, ev_hit, ev_bit;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:1];
  assign wr_ok   = reg_wr & stby_pg;
  assign clr_req = wr_ok & (reg_addr == TAMPER_ADDR) & ~reg_wdata[0] & ~tamper_n_i;
  assign pend_in = pend_q | rst_bat_por;

  tamper_bat_core core_i (
    .clk(clk), .rst_bat_por(rst_bat_por), .rst_stby_por(rst_stby_por),
    .stby_pg(stby_pg), .tamper_n_i(tamper_n_i), .clr_req(clr_req),
    .flag_o(flag_q), .pend_o(pend_q), .fall_o(fall)
  );

  assign ev_pg[EV_WAKE] = stby_pg;
  assign ev_pg[EV_SMI]  = stby_pg & main_pg;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    localparam logic [ADDR_W-1:0] STS_A = (g == EV_WAKE) ? WAKE_STS_ADDR : SMI_STS_ADDR;
    localparam logic [ADDR_W-1:0] EN_A  = (g == EV_WAKE) ? WAKE_EN_ADDR  : SMI_EN_ADDR;
    tamper_evt_path #(.ADDR_W(ADDR_W), .STS_ADDR(STS_A), .EN_ADDR(EN_A)) path_i (
      .clk(clk), .rst_stby_por(rst_stby_por), .pend_in(pend_in),
      .stby_pg(stby_pg), .out_pg(ev_pg[g]), .fall(fall), .wr_ok(wr_ok),
      .addr(reg_addr), .wbit(reg_wdata[0]),
      .sts_o(ev_sts[g]), .en_o(ev_en[g]), .evt_o(ev_out[g]),
      .rd_hit(ev_hit[g]), .rd_bit(ev_bit[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == TAMPER_ADDR)
      reg_rdata[1:0] = {tamper_n_i, flag_q};
    for (int i = 0; i < NUM_EV; i++)
      if (ev_hit[i]) reg_rdata[0] = ev_bit[i];
  end

  assign wake_o = ev_out[EV_WAKE];
  assign smi_o  = ev_out[EV_SMI];
endmodule

// File: rtl/tamper_latch_chk.sv
module tamper_latch_chk #(
  parameter int NUM_EV = 2
) (
  input logic              clk,
  input logic              rst_bat_por,
  input logic              rst_stby_por,
  input logic              stby_pg,
  input logic              main_pg,
  input logic              tamper_n_i,
  input logic              wake_o,
  input logic              smi_o,
  input logic              flag_q,
  input logic [NUM_EV-1:0] en_q
);
  logic pin_prev;
  always_ff @(posedge clk) begin
    if (rst_bat_por) pin_prev <= 1'b1;
    else             pin_prev <= tamper_n_i;
  end

  assert_fall_sets_flag_R1: assert property (@(posedge clk) disable iff (rst_bat_por)
    (pin_prev && !tamper_n_i) |=> flag_q);

  assert_bat_por_flag_R3: assert property (@(posedge clk) disable iff (rst_stby_por)
    rst_bat_por |=> flag_q);

  assert_stby_por_clear_R4: assert property (@(posedge clk) disable iff (rst_bat_por)
    rst_stby_por |=> (en_q == '0 && !wake_o && !smi_o));

  assert_flag_hold_pin_high_R5: assert property (@(posedge clk) disable iff (rst_bat_por)
    (flag_q && tamper_n_i) |=> flag_q);

  assert_wake_needs_stby_R7: assert property (@(posedge clk) disable iff (rst_bat_por || rst_stby_por)
    wake_o |-> $past(stby_pg));

  assert_smi_needs_main_R8: assert property (@(posedge clk) disable iff (rst_bat_por || rst_stby_por)
    smi_o |-> ($past(main_pg) && $past(stby_pg)));

  assert_no_write_unpowered_R10: assert property (@(posedge clk) disable iff (rst_bat_por || rst_stby_por)
    !stby_pg |=> $stable(en_q));
endmodule

bind chassis_tamper_latch tamper_latch_chk #(.NUM_EV(tamper_pkg::NUM_EV)) chk_i (
  .clk(clk), .rst_bat_por(rst_bat_por), .rst_stby_por(rst_stby_por),
  .stby_pg(stby_pg), .main_pg(main_pg), .tamper_n_i(tamper_n_i),
  .wake_o(wake_o), .smi_o(smi_o), .flag_q(flag_q), .en_q(ev_en)
);

// File: tb/chassis_tamper_latch_tb.sv
`timescale 1ns/1ps
module chassis_tamper_latch_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] A_TMP = 8'h5E, A_WS = 8'h40, A_WE = 8'h41, A_SS = 8'h42, A_SE = 8'h43;

  logic clk = 1'b0;
  logic rst_bat_por, rst_stby_por, stby_pg, main_pg, tamper_n_i, reg_wr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic wake_o, smi_o;

  always #2 clk = ~clk;

  chassis_tamper_latch dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // reference model state
  bit m_pin_q, m_flag, m_pend;
  bit m_sts[2], m_en[2], m_out[2];

  function automatic logic [7:0] model_read(logic [7:0] a, bit pin);
    logic [7:0] r = 8'h00;
    case (a)
      A_TMP: r = {6'b0, pin, m_flag};
      A_WS:  r[0] = m_sts[0];
      A_WE:  r[0] = m_en[0];
      A_SS:  r[0] = m_sts[1];
      A_SE:  r[0] = m_en[1];
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic model_tick();
    bit fall, wr_ok, pend_in, pg[2];
    logic [7:0] sa[2], ea[2];
    sa[0] = A_WS; sa[1] = A_SS; ea[0] = A_WE; ea[1] = A_SE;
    pg[0] = stby_pg; pg[1] = stby_pg & main_pg;
    fall    = m_pin_q & ~tamper_n_i & ~rst_bat_por;
    wr_ok   = reg_wr & stby_pg;
    pend_in = m_pend | rst_bat_por;
    for (int i = 0; i < 2; i++) begin
      if (rst_stby_por) begin
        m_sts[i] = pend_in; m_en[i] = 0; m_out[i] = 0;
      end else begin
        m_out[i] = m_sts[i] & m_en[i] & pg[i];
        if (stby_pg) begin
          bit ns, ne;
          ns = m_sts[i]; ne = m_en[i];
          if (fall) ns = 1;
          else if (wr_ok && reg_addr == sa[i] && reg_wdata[0]) ns = 0;
          if (wr_ok && reg_addr == ea[i]) ne = reg_wdata[0];
          m_sts[i] = ns; m_en[i] = ne;
        end
      end
    end
    if (rst_bat_por) begin
      m_pin_q = 1; m_flag = 1; m_pend = 1;
    end else begin
      if (fall || (rst_stby_por && m_pend)) m_flag = 1;
      else if (wr_ok && reg_addr == A_TMP && !reg_wdata[0] && !tamper_n_i) m_flag = 0;
      if (fall && !stby_pg) m_pend = 1;
      else if (rst_stby_por) m_pend = 0;
      m_pin_q = tamper_n_i;
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: model and DUT advance together, then compare after the edge
  task automatic step(string req);
    model_tick();
    @(posedge clk); #1;
    check({req, " read"}, reg_rdata, model_read(reg_addr, tamper_n_i));
    check({req, " wake_o R7"}, {7'b0, wake_o}, {7'b0, m_out[0]});
    check({req, " smi_o R8"}, {7'b0, smi_o}, {7'b0, m_out[1]});
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string req);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step(req);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    reg_addr = a;
    step(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 200000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_bat_por = 1; rst_stby_por = 1; stby_pg = 1; main_pg = 0;
    tamper_n_i = 1; reg_wr = 0; reg_addr = A_TMP; reg_wdata = 0;
    @(negedge clk);
    step("R3 reset");
    step("R3 reset");
    rst_bat_por = 0; rst_stby_por = 0;
    rd(A_TMP, "R3 flag after battery reset");
    rd(A_WS, "R4 wake status from pending");
    rd(A_SE, "R4 enable cleared");
    // R5: clear ignored with pin high, write 1 no effect
    wr(A_TMP, 8'h00, "R5 clear with pin high");
    tamper_n_i = 0;
    step("R1 fall edge");
    wr(A_TMP, 8'h01, "R5 write one no effect");
    wr(A_TMP, 8'h00, "R5 clear with pin low");
    rd(A_TMP, "R5 flag cleared");
    wr(A_WS, 8'h01, "R6 clear wake status");
    wr(A_SS, 8'h01, "R6 clear smi status");
    rd(A_SS, "R6 status cleared");
    tamper_n_i = 1; step("R1 pin released");
    tamper_n_i = 0; step("R1 second fall");
    rd(A_TMP, "R1 flag set");
    rd(A_WS, "R6 status set by fall");
    // R9: enable on pending status
    wr(A_WE, 8'h01, "R9 wake enable");
    rd(A_WE, "R9 wake fires");
    rd(A_WE, "R7 wake level");
    wr(A_SE, 8'h01, "R8 smi enable without main");
    step("R8 smi held low");
    main_pg = 1; step("R8 main up");
    step("R8 smi asserted");
    wr(A_WS, 8'h01, "R7 clear wake status");
    step("R7 wake drops");
    // R2/R10: battery only
    stby_pg = 0; main_pg = 0; tamper_n_i = 1;
    step("R2 standby lost");
    wr(A_TMP, 8'h00, "R10 write ignored unpowered");
    tamper_n_i = 0; step("R2 battery-only fall");
    wr(A_WE, 8'h00, "R10 enable write ignored");
    stby_pg = 1; rst_stby_por = 1; step("R4 standby reset");
    rst_stby_por = 0;
    rd(A_WS, "R4 wake status replayed");
    rd(A_SS, "R4 smi status replayed");
    rd(A_TMP, "R4 flag forced");
    rd(8'h10, "R10 unmapped read");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] addrs[6];
      addrs[0] = A_TMP; addrs[1] = A_WS; addrs[2] = A_WE;
      addrs[3] = A_SS; addrs[4] = A_SE; addrs[5] = 8'h07;
      if ($urandom_range(0, 5) == 0) tamper_n_i = ~tamper_n_i;
      stby_pg = ($urandom_range(0, 9) != 0);
      main_pg = $urandom_range(0, 1);
      rst_stby_por = ($urandom_range(0, 99) == 0);
      reg_wr = $urandom_range(0, 1);
      reg_addr = addrs[$urandom_range(0, 5)];
      reg_wdata = 8'($urandom);
      step("R1 R2 R4 R5 R6 R9 R10 random");
    end
    rst_stby_por = 0; reg_wr = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule